// File: doc/BRIEF.md
# Converter Sample Pattern Monitor

The block watches a stream of converter samples and decides whether they follow a chosen test pattern. Three families are offered: a pseudo-random word sequence, a ramp in which every 4-bit nibble counts up on its own, and a ramp in which the whole word counts up and wraps. The monitor keeps a predicted value for the next sample. While locked, the prediction runs freely from its own previous value. While unlocked, it is rebuilt from each received sample, so the monitor can find the phase of the stream without help.

Zero words get special handling, because ramps pass through zero as a legitimate value. A lone all-zero sample seen while locked raises no error. A run of such samples, or of mismatching samples, still breaks the lock. Two outputs report the result. `oos` shows the lock state. `err` is a sticky flag that records any non-zero mismatch seen while locked and stays set until it is cleared.

The sample input is a valid/ready stream. `s_ready` is always high: the monitor never applies back-pressure, and every cycle with `s_valid` high hands it one sample.

Top module: `pat_monitor`

## Requirements
- R1: After reset, `oos` is 1, `err` is 0 and the stored prediction is 0. `s_ready` is 1 in every cycle.
- R2: `pat_sel` picks the pattern rule next(v). Code 0 is a one-step Galois LFSR: next = (v >> 1) XOR (v[0] ? TAPS : 0), with TAPS = 16'hB400 by default. Code 1 adds one to each 4-bit nibble, modulo 16 per nibble. Codes 2 and 3 add one to the whole word, modulo 2^W.
- R3: While `oos` is 1, every valid sample d sets the prediction to next(d). A sample that is non-zero and equal to the prediction extends a match run; any other sample clears the run. When the run reaches OOS_THRESHOLD, `oos` falls to 0 and the run restarts.
- R4: While locked, a valid non-zero sample equal to the prediction clears the bad-run count. In every locked valid cycle the prediction becomes next(prediction).
- R5: While locked, an all-zero sample never sets `err`. It adds one to the bad-run count, whether or not it matches.
- R6: While locked, a valid non-zero sample that differs from the prediction sets `err` and adds one to the bad-run count.
- R7: When the bad-run count reaches OOS_THRESHOLD, `oos` rises to 1 and the count restarts.
- R8: `err` holds its value until `err_clr` is 1 in some cycle. If a set and a clear fall in the same cycle, the set wins.
- R9: A cycle with `s_valid` low leaves `oos`, `err` (apart from a clear), the prediction and the run count unchanged.
- R10: While `oos` is 1, no sample sets `err`.
- R11: `oos` and `err` are registered. A sample accepted at one clock edge shows its effect on the outputs immediately after that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample present this cycle |
| s_ready | output | 1 | Always 1; the monitor never stalls |
| s_data | input | W | Received sample word |
| pat_sel | input | 2 | Pattern code (see R2) |
| err_clr | input | 1 | Clears the sticky error flag |
| oos | output | 1 | High while the monitor is not locked |
| err | output | 1 | Sticky mismatch flag |

## Verification
Every result depends on a single register stage. A sample presented with `s_valid` at one rising edge changes `oos` and `err` directly after that edge, and a clear acts with the same latency. The bench drives its inputs on falling edges and advances its reference model by one sample. It compares both outputs one nanosecond after the following rising edge, so every comparison lands on the cycle in which the result is due. Directed runs cover the exact sample count to lock, to single-zero tolerance and to loss of lock. Seeded random streams mix in idle cycles, zeros, corruptions and clears.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PAT_PN    = 2'd0,
    PAT_NIB   = 2'd1,
    PAT_RAMP  = 2'd2,
    PAT_RAMP3 = 2'd3
  } pm_pat_e;
endpackage

// File: rtl/pm_pattern_gen.sv
module pm_pattern_gen #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic [W-1:0] base,
  input  logic [1:0]   sel,
  output logic [W-1:0] nxt
);
  import pm_pkg::*;
  localparam int NIBS = W / 4;

  logic [W-1:0] pn_next;
  logic [W-1:0] nib_next;
  logic [W-1:0] ramp_next;

  assign pn_next   = (base >> 1) ^ (base[0] ? TAPS : '0);
  assign ramp_next = base + 1'b1;

  for (genvar g = 0; g < NIBS; g++) begin : g_lane
    assign nib_next[4*g +: 4] = base[4*g +: 4] + 4'd1;
  end
  if (W > 4*NIBS) begin : g_tail
    assign nib_next[W-1:4*NIBS] = base[W-1:4*NIBS];
  end

  always_comb begin
    unique case (pm_pat_e'(sel))
      PAT_PN:  nxt = pn_next;
      PAT_NIB: nxt = nib_next;
      default: nxt = ramp_next;
    endcase
  end
endmodule

// File: rtl/pm_sync_tracker.sv
module pm_sync_tracker #(
  parameter int THRESH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic is_zero,
  input  logic is_match,
  output logic oos,
  output logic err_set
);
  localparam int CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

  logic [CW-1:0] run_q;
  logic          good;

  assign good    = is_match && !is_zero;
  assign err_set = valid && !oos && !is_zero && !is_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oos   <= 1'b1;
      run_q <= '0;
    end else if (valid) begin
      if (oos) begin
        if (!good) begin
          run_q <= '0;
        end else if (run_q == LAST) begin
          oos   <= 1'b0;
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        if (good) begin
          run_q <= '0;
        end else if (run_q == LAST) begin
          oos   <= 1'b1;
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pat_monitor.sv
module pat_monitor #(
  parameter int           W             = 16,
  parameter int           OOS_THRESHOLD = 4,
  parameter logic [W-1:0] TAPS          = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  input  logic [1:0]   pat_sel,
  input  logic         err_clr,
  output logic         oos,
  output logic         err
);
  logic [W-1:0] pred_q;
  logic [W-1:0] gen_base;
  logic [W-1:0] gen_next;
  logic         is_zero;
  logic         is_match;
  logic         err_set;
  logic         oos_w;

  assign s_ready  = 1'b1;
  assign is_zero  = (s_data == '0);
  assign is_match = (s_data == pred_q);
  assign gen_base = oos_w ? s_data : pred_q;

  pm_pattern_gen #(.W(W), .TAPS(TAPS)) gen_i (
    .base (gen_base),
    .sel  (pat_sel),
    .nxt  (gen_next)
  );

  pm_sync_tracker #(.THRESH(OOS_THRESHOLD)) trk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (s_valid),
    .is_zero  (is_zero),
    .is_match (is_match),
    .oos      (oos_w),
    .err_set  (err_set)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_q <= '0;
      err    <= 1'b0;
    end else begin
      if (s_valid) pred_q <= gen_next;
      if (err_set)      err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end

  assign oos = oos_w;
endmodule

// File: rtl/pat_monitor_checker.sv
module pat_monitor_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         s_valid,
  input logic [W-1:0] s_data,
  input logic         err_clr,
  input logic         oos,
  input logic         err
);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(err_clr));

  assert_idle_keeps_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> $stable(oos));

  assert_idle_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_valid && !err) |=> !err);

  assert_zero_no_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !oos && s_data == '0 && !err) |=> !err);

  assert_unlocked_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (oos && !err) |=> !err);

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(s_valid && !oos && s_data != '0));
endmodule

bind pat_monitor pat_monitor_checker #(.W(W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_valid (s_valid),
  .s_data  (s_data),
  .err_clr (err_clr),
  .oos     (oos),
  .err     (err)
);

// File: tb/pat_monitor_tb_top.sv
`timescale 1ns/1ps
module pat_monitor_tb_top;
  localparam int W = 16;
  localparam int T = 4;
  localparam logic [W-1:0] TAPS = 16'hB400;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [W-1:0] s_data = '0;
  logic [1:0]   pat_sel = 2'd2;
  logic         err_clr = 1'b0;
  logic         oos;
  logic         err;

  int checks = 0;
  int errors = 0;

  logic         m_oos, m_err;
  logic [W-1:0] m_pred;
  int           m_cnt;
  logic [W-1:0] src;

  always #2.5 clk = ~clk;

  pat_monitor #(.W(W), .OOS_THRESHOLD(T), .TAPS(TAPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .pat_sel(pat_sel), .err_clr(err_clr),
    .oos(oos), .err(err)
  );

  function automatic logic [W-1:0] f_next(input logic [W-1:0] v, input logic [1:0] sel);
    logic [W-1:0] r;
    case (sel)
      2'd0: r = (v >> 1) ^ (v[0] ? TAPS : '0);
      2'd1: begin
        for (int i = 0; i < W/4; i++) r[4*i +: 4] = v[4*i +: 4] + 4'd1;
      end
      default: r = v + 1'b1;
    endcase
    return r;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (oos !== m_oos || err !== m_err || s_ready !== 1'b1) begin
      errors++;
      $display("FAIL %s: oos=%0b err=%0b ready=%0b expected oos=%0b err=%0b ready=1",
               tag, oos, err, s_ready, m_oos, m_err);
    end
  endtask

  // one cycle: drive on falling edge, update model, compare after the rising edge
  task automatic step(input logic v, input logic [W-1:0] d, input logic clr, input string tag);
    logic zero, match, setf;
    @(negedge clk);
    s_valid = v; s_data = d; err_clr = clr;
    setf = 1'b0;
    if (v) begin
      zero  = (d == '0);
      match = (d == m_pred);
      if (m_oos) begin
        m_pred = f_next(d, pat_sel);
        if (match && !zero) begin
          if (m_cnt + 1 == T) begin m_oos = 1'b0; m_cnt = 0; end
          else m_cnt++;
        end else m_cnt = 0;
      end else begin
        m_pred = f_next(m_pred, pat_sel);
        if (match && !zero) m_cnt = 0;
        else begin
          if (!zero) setf = 1'b1;
          if (m_cnt + 1 == T) begin m_oos = 1'b1; m_cnt = 0; end
          else m_cnt++;
        end
      end
    end
    if (setf) m_err = 1'b1;
    else if (clr) m_err = 1'b0;
    @(posedge clk);
    #1;
    check(tag);
  endtask

  task automatic send_src(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1'b1, src, 1'b0, tag);
      src = f_next(src, pat_sel);
    end
  endtask

  initial begin
    m_oos = 1'b1; m_err = 1'b0; m_pred = '0; m_cnt = 0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1");
    @(negedge clk); rst_n = 1'b1;

    // R3: lock onto full ramp; first sample reseeds, then T matches
    pat_sel = 2'd2; src = 16'd100;
    send_src(T, "R3");
    if (oos !== 1'b1) begin errors++; $display("FAIL R3: locked early oos=%0b expected 1", oos); end
    checks++;
    send_src(1, "R3");
    send_src(3, "R4");

    // R5: single zero while locked
    step(1'b1, '0, 1'b0, "R5");
    src = f_next(src, pat_sel);
    send_src(2, "R5");

    // R9: idle cycles with garbage data
    step(1'b0, 16'h5A5A, 1'b0, "R9");
    step(1'b0, 16'h0000, 1'b0, "R9");

    // R2/R5: ramp wrap through natural zero
    src = 16'hFFFD;
    pat_sel = 2'd3;
    for (int i = 0; i < T + 1; i++) step(1'b1, 16'h1111 + 16'(i), 1'b0, "R3");
    src = 16'hFFFD;
    send_src(T + 1, "R2");
    send_src(6, "R5");

    // R6 / R8: mismatch sets err; set beats clear; clear works
    step(1'b1, src ^ 16'h0100, 1'b1, "R8");
    src = f_next(src, pat_sel);
    step(1'b0, '0, 1'b0, "R8");
    step(1'b0, '0, 1'b1, "R8");
    step(1'b1, src ^ 16'h0001, 1'b0, "R6");
    src = f_next(src, pat_sel);
    send_src(1, "R4");
    step(1'b0, '0, 1'b1, "R8");

    // R7: T consecutive zeros lose lock
    for (int i = 0; i < T; i++) step(1'b1, '0, 1'b0, "R7");

    // R10: garbage while unlocked never sets err
    for (int i = 0; i < 5; i++) step(1'b1, 16'(($urandom() % 16'hFFFF) + 1), 1'b0, "R10");

    // R2: nibble ramp, PN
    pat_sel = 2'd1; src = 16'hE7F2;
    send_src(T + 4, "R2");
    pat_sel = 2'd0; src = 16'hACE1;
    send_src(T + 4, "R2");
    step(1'b1, src ^ 16'h8000, 1'b0, "R6");
    src = f_next(src, pat_sel);
    step(1'b0, '0, 1'b1, "R8");

    // mixed random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic v, clr;
      logic [W-1:0] d;
      r = int'($urandom() % 200);
      if (r == 0) begin
        pat_sel = 2'($urandom());
        src = 16'($urandom()) | 16'h0001;
      end
      v = ($urandom() % 4) != 0;
      clr = ($urandom() % 60) == 0;
      d = src;
      r = int'($urandom() % 64);
      if (r < 2) d = '0;
      else if (r < 3) d = src ^ 16'(1 << ($urandom() % 16));
      else if (r < 4 && ($urandom() % 8) == 0) begin
        for (int k = 0; k < T; k++) step(1'b1, '0, 1'b0, "R7");
      end
      step(v, d, clr, "R11");
      if (v) src = f_next(src, pat_sel);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #150000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule